// File: doc/BRIEF.md
# SMBus Stuck-Bus Timeout Monitor

This block runs next to an SMBus target and watches the two bus lines for a stuck-low condition while the target reports a transfer in progress. Each line has its own watcher. A prescaler divides the system clock into coarse ticks, and a tick counter compares the elapsed low time against a limit. With the default parameters the limit is 25 ms at 50 MHz. When either watcher reaches its limit, the block sends a one-cycle abort pulse. The target uses this pulse to return its state machine to idle and to release SDA, so a device that stops in the middle of a transfer cannot hold the bus forever.

A host-writable configuration byte holds the two watch enables, one for the clock line and one for the data line. Both enables are clear after reset, so the monitor does nothing until software turns a watcher on. A two-bit sticky status records which line caused a timeout. Software clears each status bit by writing a one to it.

The inputs are expected to be already synchronized to `clk_i`. The block does not decode the protocol.

Top module: `smbto_monitor`

## Requirements
- R1: After reset, `abort_o` is 0, `status_o` is 2'b00, and both watch enables are off, so no stuck line produces an abort.
- R2: Writing `cfg_wdata_i` with `cfg_we_i` high loads the enables. Bit 5 enables the SDA watcher and bit 4 enables the SCL watcher. All other bits have no effect, and a disabled line never causes an abort.
- R3: A line counts as stuck when it is enabled, is low, and `busy_i` is high. Let N = TICK_DIV*LIMIT_TICKS, and let edge 1 be the first clock edge that samples the line low. If the line stays stuck through edge N+1, `abort_o` is high for the cycle that follows edge N+1. If the line rises before edge N+1, no abort occurs.
- R4: Any transition of a watched line restarts its count from zero.
- R5: A watcher counts only while `busy_i` is high. Any cycle with `busy_i` low clears its count.
- R6: Each stuck episode gives exactly one abort pulse, however long the line stays low. A watcher re-arms only after a line transition, a drop of `busy_i`, or removal of its enable.
- R7: A timeout sets its status bit on the same edge that raises `abort_o`: bit 0 for SCL, bit 1 for SDA. The bit stays set until it is cleared.
- R8: A one on bit k of `stat_clr_i` clears status bit k at the next edge and leaves the other bit unchanged. A timeout in the same cycle as a clear wins.
- R9: The two watchers are independent. Either one alone can cause an abort. When both lines are stuck together, a single pulse results and both status bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| busy_i | input | 1 | Target reports a transfer in progress |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_wdata_i | input | 8 | Configuration byte (bit 5 SDA enable, bit 4 SCL enable) |
| stat_clr_i | input | 2 | Write-one-to-clear for the status bits |
| abort_o | output | 1 | One-cycle abort pulse to the target |
| status_o | output | 2 | Sticky timeout status (bit 0 SCL, bit 1 SDA) |

## Verification
A tick counter or prescaler that has slipped moves the abort pulse by at least one cycle. This is visible at the ports as soon as the limit is reached. The bench therefore holds a line low for exactly N and N+1 sampled edges. A done flag that never clears shows up as a missing abort on the next episode. A done flag that never sets shows up as repeated pulses during a long stuck period. A count that is not cleared by an edge or by a drop of the busy flag produces an abort early, after two partial low periods that are each too short to time out on their own.

// File: rtl/smbto_pkg.sv
package smbto_pkg;
  localparam int unsigned CfgSdaEnBit = 5;
  localparam int unsigned CfgSclEnBit = 4;
  localparam int unsigned NumLines    = 2;

  typedef enum logic [0:0] {
    LINE_SCL = 1'b0,
    LINE_SDA = 1'b1
  } line_idx_e;

  typedef struct packed {
    logic sda_en;
    logic scl_en;
  } cfg_t;

  function automatic cfg_t cfg_decode(input logic [7:0] wdata);
    cfg_t c;
    c.sda_en = wdata[CfgSdaEnBit];
    c.scl_en = wdata[CfgSclEnBit];
    return c;
  endfunction
endpackage

// File: rtl/smbto_tick.sv
module smbto_tick #(
  parameter int unsigned TICK_DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LastVal = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LastVal);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/smbto_line.sv
module smbto_line #(
  parameter int unsigned TICK_DIV    = 50,
  parameter int unsigned LIMIT_TICKS = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic en_i,
  input  logic busy_i,
  output logic hit_o
);
  localparam int unsigned TW = $clog2(LIMIT_TICKS + 1);
  localparam logic [TW-1:0] LastTick = TW'(LIMIT_TICKS - 1);

  logic          line_q;
  logic          done_q;
  logic [TW-1:0] tcnt_q;
  logic          edge_seen;
  logic          armed;
  logic          restart;
  logic          tick;
  logic          at_last;

  assign edge_seen = line_i ^ line_q;
  assign armed     = en_i & busy_i & ~line_i;
  assign restart   = edge_seen | ~armed;
  assign at_last   = (tcnt_q == LastTick);
  assign hit_o     = armed & ~edge_seen & tick & at_last & ~done_q;

  smbto_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b1;
      tcnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      line_q <= line_i;
      if (restart) begin
        tcnt_q <= '0;
        done_q <= 1'b0;
      end else begin
        if (tick && !at_last) tcnt_q <= tcnt_q + 1'b1;
        if (hit_o)            done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/smbto_monitor.sv
module smbto_monitor
  import smbto_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 50,
  parameter int unsigned LIMIT_TICKS = 25000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       busy_i,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_wdata_i,
  input  logic [1:0] stat_clr_i,
  output logic       abort_o,
  output logic [1:0] status_o
);
  cfg_t                cfg_q;
  logic [NumLines-1:0] line_vec;
  logic [NumLines-1:0] en_vec;
  logic [NumLines-1:0] hit_vec;
  logic                abort_q;
  logic [NumLines-1:0] status_q;

  assign line_vec[LINE_SCL] = scl_i;
  assign line_vec[LINE_SDA] = sda_i;
  assign en_vec[LINE_SCL]   = cfg_q.scl_en;
  assign en_vec[LINE_SDA]   = cfg_q.sda_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_decode(cfg_wdata_i);
  end

  for (genvar g = 0; g < NumLines; g++) begin : g_line
    smbto_line #(
      .TICK_DIV    (TICK_DIV),
      .LIMIT_TICKS (LIMIT_TICKS)
    ) u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (line_vec[g]),
      .en_i   (en_vec[g]),
      .busy_i (busy_i),
      .hit_o  (hit_vec[g])
    );
  end

  // set has priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abort_q  <= 1'b0;
      status_q <= '0;
    end else begin
      abort_q  <= |hit_vec;
      status_q <= (status_q & ~stat_clr_i) | hit_vec;
    end
  end

  assign abort_o  = abort_q;
  assign status_o = status_q;
endmodule

// File: rtl/smbto_monitor_chk.sv
module smbto_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic [1:0] en_i,
  input logic [1:0] stat_clr_i,
  input logic       abort_o,
  input logic [1:0] status_o
);
  p_disabled_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == 2'b00) |=> !abort_o);

  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !abort_o);

  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (!abort_o || ($countones(status_o) == 2)));

  p_scl_set_with_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> abort_o);

  p_sda_set_with_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> abort_o);

  p_scl_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !stat_clr_i[0]) |=> status_o[0]);

  p_sda_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] && !stat_clr_i[1]) |=> status_o[1]);

  p_scl_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_i[0] |=> (!status_o[0] || abort_o));

  p_sda_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_i[1] |=> (!status_o[1] || abort_o));
endmodule

bind smbto_monitor smbto_monitor_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_i     (busy_i),
  .en_i       (en_vec),
  .stat_clr_i (stat_clr_i),
  .abort_o    (abort_o),
  .status_o   (status_o)
);

// File: tb/tb_smbto_monitor.sv
module tb_smbto_monitor;
  localparam int unsigned TICK_DIV    = 4;
  localparam int unsigned LIMIT_TICKS = 10;
  localparam int unsigned N           = TICK_DIV * LIMIT_TICKS;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_i = 1'b1;
  logic       sda_i = 1'b1;
  logic       busy_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [1:0] stat_clr_i = '0;
  logic       abort_o;
  logic [1:0] status_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  smbto_monitor #(.TICK_DIV(TICK_DIV), .LIMIT_TICKS(LIMIT_TICKS)) dut (
    .clk_i, .rst_ni, .scl_i, .sda_i, .busy_i, .cfg_we_i, .cfg_wdata_i,
    .stat_clr_i, .abort_o, .status_o
  );

  // cfg, busy, sel (0 scl, 1 sda, 2 both), hold edges, expected aborts, expected status, req
  typedef struct packed {
    logic [7:0] cfg;
    logic       busy;
    logic [1:0] sel;
    logic [7:0] hold;
    logic [1:0] exp_ab;
    logic [1:0] exp_st;
    logic [7:0] req;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{8'h00, 1'b1, 2'd0, 8'd60,  2'd0, 2'b00, 8'd1}, // R1 enables off
    '{8'h10, 1'b1, 2'd0, 8'd41,  2'd1, 2'b01, 8'd3}, // R3 limit reached
    '{8'h10, 1'b1, 2'd0, 8'd40,  2'd0, 2'b00, 8'd3}, // R3 one short
    '{8'h20, 1'b1, 2'd1, 8'd41,  2'd1, 2'b10, 8'd2}, // R2 sda enable bit 5
    '{8'h10, 1'b1, 2'd1, 8'd60,  2'd0, 2'b00, 8'd2}, // R2 scl enable ignores sda
    '{8'hCF, 1'b1, 2'd0, 8'd60,  2'd0, 2'b00, 8'd2}, // R2 other bits no effect
    '{8'h30, 1'b0, 2'd1, 8'd60,  2'd0, 2'b00, 8'd5}, // R5 not busy
    '{8'h30, 1'b1, 2'd1, 8'd120, 2'd1, 2'b10, 8'd6}, // R6 single pulse
    '{8'h30, 1'b1, 2'd0, 8'd45,  2'd1, 2'b01, 8'd9}, // R9 scl alone
    '{8'h30, 1'b1, 2'd2, 8'd45,  2'd1, 2'b11, 8'd9}  // R9 both together
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; scl_i = 1'b1; sda_i = 1'b1; busy_i = 1'b0;
    cfg_we_i = 1'b0; stat_clr_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic set_lines(input logic [1:0] sel, input logic v);
    if (sel != 2'd1) scl_i = v;
    if (sel != 2'd0) sda_i = v;
  endtask

  // hold lines low for `hold` sampled edges, return aborts seen
  task automatic hold_low(input logic [1:0] sel, input int hold, inout int ab);
    set_lines(sel, 1'b0);
    for (int i = 0; i < hold; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (abort_o) ab++;
    end
    set_lines(sel, 1'b1);
  endtask

  task automatic settle(inout int ab);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      if (abort_o) ab++;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    int ab;
    do_reset();
    // R1 reset state
    check(abort_o == 1'b0, "R1", abort_o, 0);
    check(status_o == 2'b00, "R1", status_o, 0);

    foreach (VECS[k]) begin
      do_reset();
      write_cfg(VECS[k].cfg);
      busy_i = VECS[k].busy;
      ab = 0;
      hold_low(VECS[k].sel, int'(VECS[k].hold), ab);
      settle(ab);
      check(ab == int'(VECS[k].exp_ab), $sformatf("R%0d vec%0d aborts", VECS[k].req, k), ab, VECS[k].exp_ab);
      check(status_o == VECS[k].exp_st, $sformatf("R%0d vec%0d status", VECS[k].req, k), status_o, VECS[k].exp_st);
    end

    // R4 a short high pulse restarts the count
    do_reset();
    write_cfg(8'h10); busy_i = 1'b1; ab = 0;
    hold_low(2'd0, 30, ab);
    @(negedge clk_i); @(negedge clk_i);
    hold_low(2'd0, 30, ab);
    settle(ab);
    check(ab == 0, "R4 restart on edge", ab, 0);

    // R5 a one-cycle busy drop clears the count
    do_reset();
    write_cfg(8'h20); busy_i = 1'b1; ab = 0;
    sda_i = 1'b0;
    for (int i = 0; i < 30; i++) begin @(negedge clk_i); if (abort_o) ab++; end
    busy_i = 1'b0;
    @(negedge clk_i);
    busy_i = 1'b1;
    for (int i = 0; i < 30; i++) begin @(negedge clk_i); if (abort_o) ab++; end
    sda_i = 1'b1;
    settle(ab);
    check(ab == 0, "R5 busy drop clears", ab, 0);

    // R6 re-arm after line edge gives a second pulse
    do_reset();
    write_cfg(8'h10); busy_i = 1'b1; ab = 0;
    hold_low(2'd0, 45, ab);
    @(negedge clk_i);
    hold_low(2'd0, 45, ab);
    settle(ab);
    check(ab == 2, "R6 re-arm", ab, 2);

    // R7 sticky, R8 per-bit clear
    check(status_o == 2'b01, "R7 status set", status_o, 1);
    repeat (20) @(negedge clk_i);
    check(status_o == 2'b01, "R7 sticky", status_o, 1);
    stat_clr_i = 2'b10;
    @(negedge clk_i);
    stat_clr_i = 2'b00;
    check(status_o == 2'b01, "R8 other bit kept", status_o, 1);
    stat_clr_i = 2'b01;
    @(negedge clk_i);
    stat_clr_i = 2'b00;
    check(status_o == 2'b00, "R8 cleared", status_o, 0);

    done = 1'b1;
    finish_run();
  end
endmodule